// File: doc/BRIEF.md
# DC-Balanced Three-Lane Serial Encoder

This block is the transmit half of a three-lane DC-balanced serial link. Each parallel word of 21 bits is cut into three 7-bit groups, one per data lane. Every lane keeps a running digital sum: a transmitted 1 adds one and a transmitted 0 subtracts one. When a group's own disparity and the lane's running sum point the same way, the group is sent inverted. Two complementary marker bits go in front of each group, so every lane sends a 9-bit frame for each word.

A fourth lane carries a forwarded clock pattern, also 9 bits per word. Its high time changes between four and five bits on successive words, so that this lane is balanced as well. All lanes advance one bit on each clock cycle where the bit enable is high. The block takes the next word on the enable cycle that finishes the current frame and signals that cycle on `wordAccept`. A matching receiver strips the markers and undoes the inversion, which gives back the original word.

Top module: `dcbal_encoder`

## Requirements
- R1: After synchronous reset all four serial outputs are 0, every lane's running sum is zero, the first word is sent uninverted (marker A = 0), and the first clock-lane frame is the short (4-high) one.
- R2: `wordAccept` is high exactly when `bitEn` is high and the frame in flight has sent all 9 bits, or no frame has started since reset. The word on `wordIn` is captured at that clock edge.
- R3: Lane k carries `wordIn[7k+6:7k]`. Each frame is sent as marker A, then marker B, then payload bit 6 down to bit 0. Marker A appears on the output right after the capturing edge, and each later enabled edge moves on by one bit.
- R4: A group is inverted when the lane's running sum and the group disparity (2·ones − 7) are both positive or both negative. Otherwise it is sent true. Marker A = 1 marks an inverted group, and marker B is always the complement of marker A.
- R5: The running sum changes by the disparity of the payload actually sent; the marker pair adds nothing. At frame boundaries the sum stays within ±7. Counted bit by bit on the serial output, it stays within ±10.
- R6: Counting from reset, clock-lane frames with an even index send 4 ones followed by 5 zeros. Frames with an odd index send 5 ones followed by 4 zeros. The clock lane's running sum therefore varies by at most 5.
- R7: While `bitEn` is low, no output changes and no frame position advances.
- R8: A reset in the middle of a frame drops that frame and returns the block to the R1 state.
- R9: For every frame, a receiver that inverts the payload when marker A = 1 recovers the original 7-bit group exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | Bit enable; one serial bit per high cycle |
| wordIn | input | 21 | Parallel word, captured when wordAccept is high |
| wordAccept | output | 1 | High on the cycle whose edge captures wordIn |
| laneOut | output | 3 | Serial data lanes, bit k is lane k |
| clkLaneOut | output | 1 | Serial forwarded-clock lane |

## Verification
The assertions take for granted that reset is held for at least one edge before any bit enable, and that `wordIn` is stable whenever `wordAccept` is high. The bench drives a new word only on the accepting cycle and puts a reset first. The bench inserts random idle gaps in `bitEn` so that the hold-while-disabled property has real stretches to act on. It also drives directed words of all ones and all zeros, which push the running sum to its ±7 extremes, the point where the ±10 serial bound is tightest.

// File: rtl/dcbal_pkg.sv
package dcbal_pkg;

  // Strobes from the frame sequencer to the datapath
  typedef struct packed {
    logic load;      // capture a new word into every lane
    logic shift;     // advance every lane by one bit
    logic longHigh;  // clock-lane frame being loaded uses the long high time
  } ctrlStb_t;

endpackage

// File: rtl/dcbal_ctrl.sv
module dcbal_ctrl
  import dcbal_pkg::*;
#(
  parameter int FRAME_W = 9
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bitEn,
  output ctrlStb_t stb
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             longPhase;

  always_comb begin
    stb.load     = bitEn && (bitCnt == LAST);
    stb.shift    = bitEn && (bitCnt != LAST);
    stb.longHigh = longPhase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt    <= LAST;
      longPhase <= 1'b0;
    end else if (stb.load) begin
      bitCnt    <= '0;
      longPhase <= ~longPhase;
    end else if (stb.shift) begin
      bitCnt    <= bitCnt + 1'b1;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= LAST);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> $stable(bitCnt) && $stable(longPhase));

endmodule

// File: rtl/dcbal_lane.sv
module dcbal_lane #(
  parameter int GROUP_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadStb,
  input  logic               shiftStb,
  input  logic [GROUP_W-1:0] group,
  output logic               serOut
);

  localparam int FRAME_W = GROUP_W + 2;
  localparam int SUM_W   = $clog2(2 * GROUP_W + 1) + 1;
  localparam logic signed [SUM_W-1:0] GROUP_C = SUM_W'(GROUP_W);

  logic signed [SUM_W-1:0] runSum;
  logic signed [SUM_W-1:0] disp;
  logic signed [SUM_W-1:0] sentDisp;
  logic [SUM_W-1:0]        ones;
  logic                    invert;
  logic [FRAME_W-1:0]      frame;
  logic [FRAME_W-1:0]      shiftReg;

  always_comb begin
    ones = '0;
    for (int i = 0; i < GROUP_W; i++) ones = ones + SUM_W'(group[i]);
    disp     = $signed(ones << 1) - GROUP_C;
    invert   = ((runSum > 0) && (disp > 0)) || ((runSum < 0) && (disp < 0));
    sentDisp = invert ? -disp : disp;
    frame    = {invert, ~invert, invert ? ~group : group};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runSum   <= '0;
      shiftReg <= '0;
    end else if (loadStb) begin
      runSum   <= runSum + sentDisp;
      shiftReg <= frame;
    end else if (shiftStb) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign serOut = shiftReg[FRAME_W-1];

  // R5
  sum_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (runSum <= GROUP_C) && (runSum >= -GROUP_C));

  // R1
  zero_sum_true_chk: assert property (@(posedge clk) disable iff (rst)
    (loadStb && runSum == 0) |=> !shiftReg[FRAME_W-1]);

  // R4
  marker_pair_chk: assert property (@(posedge clk) disable iff (rst)
    loadStb |=> shiftReg[FRAME_W-1] != shiftReg[FRAME_W-2]);

  // R7
  lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadStb && !shiftStb) |=> $stable(shiftReg) && $stable(runSum));

endmodule

// File: rtl/dcbal_datapath.sv
module dcbal_datapath
  import dcbal_pkg::*;
#(
  parameter int LANES   = 3,
  parameter int GROUP_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStb_t                 stb,
  input  logic [LANES*GROUP_W-1:0] wordIn,
  output logic [LANES-1:0]         laneOut,
  output logic                     clkLaneOut
);

  localparam int FRAME_W    = GROUP_W + 2;
  localparam int HIGH_SHORT = FRAME_W / 2;
  localparam int HIGH_LONG  = FRAME_W - HIGH_SHORT;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dcbal_lane #(.GROUP_W(GROUP_W)) i_lane (
      .clk     (clk),
      .rst     (rst),
      .loadStb (stb.load),
      .shiftStb(stb.shift),
      .group   (wordIn[k*GROUP_W +: GROUP_W]),
      .serOut  (laneOut[k])
    );
  end

  logic [FRAME_W-1:0] clkPattern;
  logic [FRAME_W-1:0] clkShift;

  always_comb begin
    for (int i = 0; i < FRAME_W; i++)
      clkPattern[i] = (i >= FRAME_W - (stb.longHigh ? HIGH_LONG : HIGH_SHORT));
  end

  always_ff @(posedge clk) begin
    if (rst)            clkShift <= '0;
    else if (stb.load)  clkShift <= clkPattern;
    else if (stb.shift) clkShift <= {clkShift[FRAME_W-2:0], 1'b0};
  end

  assign clkLaneOut = clkShift[FRAME_W-1];

  // R6
  clk_duty_chk: assert property (@(posedge clk) disable iff (rst)
    stb.load |=> $countones(clkShift) == ($past(stb.longHigh) ? HIGH_LONG : HIGH_SHORT));

endmodule

// File: rtl/dcbal_encoder.sv
module dcbal_encoder
  import dcbal_pkg::*;
#(
  parameter int LANES   = 3,
  parameter int GROUP_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bitEn,
  input  logic [LANES*GROUP_W-1:0] wordIn,
  output logic                     wordAccept,
  output logic [LANES-1:0]         laneOut,
  output logic                     clkLaneOut
);

  localparam int FRAME_W = GROUP_W + 2;

  ctrlStb_t stb;

  dcbal_ctrl #(.FRAME_W(FRAME_W)) i_ctrl (
    .clk  (clk),
    .rst  (rst),
    .bitEn(bitEn),
    .stb  (stb)
  );

  dcbal_datapath #(.LANES(LANES), .GROUP_W(GROUP_W)) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .wordIn    (wordIn),
    .laneOut   (laneOut),
    .clkLaneOut(clkLaneOut)
  );

  assign wordAccept = stb.load;

  // R2
  accept_en_chk: assert property (@(posedge clk) disable iff (rst)
    wordAccept |-> bitEn);

endmodule

// File: tb/test_dcbal_encoder.sv
module test_dcbal_encoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bitEn = 1'b0;
  logic [20:0] wordIn = '0;
  logic        wordAccept;
  logic [2:0]  laneOut;
  logic        clkLaneOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  int refSum [3];
  int bitSum [3];
  int clkSum, clkMin, clkMax, wordIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcbal_encoder i_dcbal_encoder (
    .clk       (clk),
    .rst       (rst),
    .bitEn     (bitEn),
    .wordIn    (wordIn),
    .wordAccept(wordAccept),
    .laneOut   (laneOut),
    .clkLaneOut(clkLaneOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] refFrame(input logic [6:0] g, inout int rs);
    int ones = 0;
    int d;
    bit inv;
    for (int i = 0; i < 7; i++) ones += g[i];
    d   = 2 * ones - 7;
    inv = (rs > 0 && d > 0) || (rs < 0 && d < 0);
    rs += inv ? -d : d;
    return {inv, ~inv, inv ? ~g : g};
  endfunction

  function automatic logic [8:0] refClk(input int idx);
    int h = (idx % 2 == 1) ? 5 : 4;
    logic [8:0] p;
    for (int i = 0; i < 9; i++) p[i] = (i >= 9 - h);
    return p;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 3; k++) begin refSum[k] = 0; bitSum[k] = 0; end
    clkSum = 0; wordIdx = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; bitEn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelReset();
    @(negedge clk);
    // R1: outputs low after reset
    check(laneOut == 3'b000, "R1 lanes low", laneOut, 0);
    check(clkLaneOut == 1'b0, "R1 clock lane low", clkLaneOut, 0);
    bitEn = 1'b1; #1;
    // R2: first enable after reset accepts a word
    check(wordAccept == 1'b1, "R2 accept after reset", wordAccept, 1);
    bitEn = 1'b0;
  endtask

  task automatic sendWord(input logic [20:0] w, input int gapMax);
    logic [8:0] exp [3];
    logic [8:0] got [3];
    logic [8:0] expClk, gotClk;
    logic [2:0] prevLane;
    logic       prevClk;
    int         peak [3];
    for (int k = 0; k < 3; k++) begin
      exp[k]  = refFrame(w[7*k +: 7], refSum[k]);
      peak[k] = 0;
    end
    expClk = refClk(wordIdx);
    @(negedge clk);
    wordIn = w; bitEn = 1'b1; #1;
    // R2: accept on the boundary cycle
    check(wordAccept == 1'b1, "R2 accept at boundary", wordAccept, 1);
    for (int b = 0; b < 9; b++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        got[k][8-b] = laneOut[k];
        bitSum[k] += laneOut[k] ? 1 : -1;
        if ((bitSum[k] < 0 ? -bitSum[k] : bitSum[k]) > peak[k])
          peak[k] = bitSum[k] < 0 ? -bitSum[k] : bitSum[k];
      end
      gotClk[8-b] = clkLaneOut;
      clkSum += clkLaneOut ? 1 : -1;
      if (clkSum < clkMin) clkMin = clkSum;
      if (clkSum > clkMax) clkMax = clkSum;
      prevLane = laneOut; prevClk = clkLaneOut;
      bitEn = 1'b0;
      wordIn = 21'($urandom);
      if (b < 8) begin
        int gaps = (gapMax > 0) ? int'($urandom_range(gapMax, 0)) : 0;
        for (int g = 0; g < gaps; g++) begin
          @(negedge clk);
          // R7: nothing moves while disabled
          check(laneOut == prevLane && clkLaneOut == prevClk, "R7 hold while idle",
                {laneOut, clkLaneOut}, {prevLane, prevClk});
        end
        bitEn = 1'b1; #1;
        // R2: no accept inside a frame
        check(wordAccept == 1'b0, "R2 no accept mid-frame", wordAccept, 0);
      end
    end
    for (int k = 0; k < 3; k++) begin
      // R3 R4: frame content and order
      check(got[k] == exp[k], "R3 R4 lane frame", got[k], exp[k]);
      // R9: receiver recovers the group
      check(got[k][8] != got[k][7] &&
            ((got[k][8] ? ~got[k][6:0] : got[k][6:0]) == w[7*k +: 7]),
            "R9 decode", got[k][6:0], w[7*k +: 7]);
      // R5: serial running sum bound
      check(peak[k] <= 10, "R5 bit sum within 10", peak[k], 10);
      if (wordIdx == 0)
        // R1: first word after reset sent true
        check(got[k][8] == 1'b0, "R1 first word uninverted", got[k][8], 0);
    end
    // R6: clock lane pattern
    check(gotClk == expClk, "R6 clock lane frame", gotClk, expClk);
    wordIdx++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clkMin = 0; clkMax = 0;
    doReset();
    // R4 R5: all ones / all zeros push the sum to its extremes
    repeat (4) sendWord(21'h1FFFFF, 0);
    repeat (4) sendWord(21'h000000, 2);
    sendWord(21'h1FC07F, 1);
    sendWord(21'h0A5A5A, 0);
    sendWord(21'h155555, 3);
    for (int n = 0; n < 300; n++) sendWord(21'($urandom), 3);
    // R8: reset in the middle of a frame
    @(negedge clk);
    wordIn = 21'h1FFFFF; bitEn = 1'b1;
    repeat (4) @(negedge clk);
    doReset();
    clkMin = 0; clkMax = 0;
    sendWord(21'h1FFFFF, 0);
    check(refSum[0] == 7, "R8 sums restart from zero", refSum[0], 7);
    sendWord(21'h1FFFFF, 0);
    for (int n = 0; n < 100; n++) sendWord(21'($urandom), 2);
    // R6: clock lane variation bound
    check(clkMax - clkMin <= 5, "R6 clock lane DSV", clkMax - clkMin, 5);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule